// File: doc/BRIEF.md
# Gated Serial Command Receiver

This block takes fixed-length commands from a slow three-wire synchronous link made of a serial clock, a framing gate and a data line. The lines arrive already synchronized to the system clock. The block finds rising edges of the serial clock in the system clock domain and shifts in one bit per edge while the gate is high. Once 64 bits have arrived, it checks the word before anything reaches the host.

The last byte of each frame carries a checksum. The leading byte is the command code. A frame is released to the host as a 56-bit command body with a one-cycle valid strobe only when the checksum matches and the command code is one of the 59 legal codes. A frame that fails either test raises its own one-cycle error flag instead. If the gate falls before a frame is complete, the partial frame is thrown away and a framing-error flag is raised.

Top module: `cmd_link_rx`

## Requirements
- R1: A bit is taken from `sdata` on each rising edge of `sclk` while `sgate` is high, most significant bit first. The first 56 bits form `cmd_body`. The command code is `cmd_body[55:48]`, and the 8-bit checksum is the final byte.
- R2: Rising edges of `sclk` while `sgate` is low shift nothing and raise no output.
- R3: A frame is accepted when two conditions hold: its final byte equals the modulo-256 sum of its first seven bytes, and its command code is below 59. An accepted frame gives exactly one `cmd_valid` pulse of one cycle, and `cmd_body` then holds its first 56 bits.
- R4: A checksum mismatch gives one `csum_err` pulse and no `cmd_valid`, and `cmd_body` keeps its previous value.
- R5: A frame with a good checksum and a command code of 59 or above gives one `code_err` pulse and no `cmd_valid`, and `cmd_body` keeps its previous value.
- R6: If `sgate` falls after 1 to 63 bits, one `frame_err` pulse is given and the partial bits are discarded. A following complete frame decodes correctly.
- R7: Once 64 bits have been taken, further `sclk` edges are ignored until `sgate` falls. A gate fall after a complete frame raises no error.
- R8: After reset all outputs are zero.
- R9: At most one of `cmd_valid`, `csum_err`, `code_err` and `frame_err` is high in any cycle.
- R10: Command codes 0 and 58 are accepted; code 59 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial link clock, synchronized |
| sgate | input | 1 | Frame gate, synchronized |
| sdata | input | 1 | Serial data, synchronized |
| cmd_body | output | 56 | Command code and parameters of the last accepted frame |
| cmd_valid | output | 1 | One-cycle strobe for an accepted frame |
| csum_err | output | 1 | One-cycle pulse: checksum mismatch |
| code_err | output | 1 | One-cycle pulse: command code not legal |
| frame_err | output | 1 | One-cycle pulse: gate fell mid-frame |

## Verification
Several valid frames are sent: different parameter bytes, and command codes at both ends of the legal range. These show that the bit order and the checksum sum are correct rather than merely self-consistent. A frame with one corrupted checksum and a frame with code 59 separate the two rejection paths from each other and from acceptance; the body is checked after each to confirm it is unchanged. Three more cases exercise the gate. A truncated frame, an over-long clock burst, and serial clock activity with the gate low show that the bit count follows the gate alone and that noise outside a frame leaves no trace.

// File: rtl/cmd_link_rx.sv
module cmd_link_rx #(
  parameter int FRAME_BITS = 64,
  parameter int NUM_CODES  = 59
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk,
  input  logic                    sgate,
  input  logic                    sdata,
  output logic [FRAME_BITS-9:0]   cmd_body,
  output logic                    cmd_valid,
  output logic                    csum_err,
  output logic                    code_err,
  output logic                    frame_err
);
  localparam int BODY_W = FRAME_BITS - 8;
  localparam int NBYTES = FRAME_BITS / 8;
  localparam int CW     = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic                  sclk_q, done;
  logic [CW-1:0]         cnt;
  logic [FRAME_BITS-1:0] shreg, next_word;
  logic [7:0]            sum;

  wire bit_stb = sclk & ~sclk_q;
  assign next_word = {shreg[FRAME_BITS-2:0], sdata};

  always_comb begin
    sum = '0;
    for (int i = 0; i < NBYTES - 1; i++)
      sum = sum + next_word[FRAME_BITS-1-8*i -: 8];
  end

  wire sum_ok  = (sum == next_word[7:0]);
  wire code_ok = int'(next_word[FRAME_BITS-1 -: 8]) < NUM_CODES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      done      <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      cmd_body  <= '0;
      cmd_valid <= 1'b0;
      csum_err  <= 1'b0;
      code_err  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      sclk_q    <= sclk;
      cmd_valid <= 1'b0;
      csum_err  <= 1'b0;
      code_err  <= 1'b0;
      frame_err <= 1'b0;
      if (!sgate) begin
        cnt  <= '0;
        done <= 1'b0;
        if (cnt != '0) frame_err <= 1'b1;
      end else if (bit_stb && !done) begin
        shreg <= next_word;
        if (cnt == LAST) begin
          cnt  <= '0;
          done <= 1'b1;
          if (!sum_ok)       csum_err <= 1'b1;
          else if (!code_ok) code_err <= 1'b1;
          else begin
            cmd_valid <= 1'b1;
            cmd_body  <= next_word[FRAME_BITS-1:8];
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, csum_err, code_err, frame_err}));

  assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> int'(cmd_body[BODY_W-1 -: 8]) < NUM_CODES);

  assert_body_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_body));

  assert_frame_err_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(!sgate));

  assert_decode_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || csum_err || code_err) |-> $past(sgate && sclk));
endmodule

// File: tb/sim_cmd_link_rx.sv
module sim_cmd_link_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 0, rst_n = 0, sclk = 0, sgate = 0, sdata = 0;
  logic [55:0] cmd_body;
  logic cmd_valid, csum_err, code_err, frame_err;

  int checks = 0, fails = 0;
  int n_valid = 0, n_csum = 0, n_code = 0, n_frame = 0;
  logic [55:0] cap_body = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_link_rx u0 (.clk, .rst_n, .sclk, .sgate, .sdata,
                  .cmd_body, .cmd_valid, .csum_err, .code_err, .frame_err);

  always @(negedge clk) begin
    if (cmd_valid) begin n_valid++; cap_body = cmd_body; end
    if (csum_err)  n_csum++;
    if (code_err)  n_code++;
    if (frame_err) n_frame++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [7:0] code, logic [47:0] prm, logic [7:0] corrupt);
    logic [55:0] b = {code, prm};
    logic [7:0] s = '0;
    for (int i = 0; i < 7; i++) s = s + b[55-8*i -: 8];
    return {b, s ^ corrupt};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [63:0] w, int nbits, int extra);
    sgate = 1; wait_clk(HALF_BIT);
    for (int i = 0; i < nbits + extra; i++) begin
      sdata = (i < 64) ? w[63-i] : ~sdata;
      sclk = 0; wait_clk(HALF_BIT);
      sclk = 1; wait_clk(HALF_BIT);
    end
    sclk = 0; wait_clk(HALF_BIT);
    sgate = 0; wait_clk(6);
  endtask

  task automatic clear_counts();
    n_valid = 0; n_csum = 0; n_code = 0; n_frame = 0;
  endtask

  task automatic t_reset();
    chk("R8 body", 64'(cmd_body), 0);
    chk("R8 flags", {60'd0, cmd_valid, csum_err, code_err, frame_err}, 0);
  endtask

  task automatic t_good(logic [7:0] code, logic [47:0] prm, string req);
    logic [63:0] w = mk(code, prm, 8'h00);
    clear_counts();
    send(w, 64, 0);
    chk({req, " valid count"}, 64'(n_valid), 1);
    chk({req, " body"}, 64'(cap_body), 64'(w[63:8]));
    chk({req, " R9 no errors"}, 64'(n_csum + n_code + n_frame), 0);
  endtask

  task automatic t_bad_sum();
    logic [55:0] prev = cap_body;
    clear_counts();
    send(mk(8'd12, 48'h0102_0304_0506, 8'h10), 64, 0);
    chk("R4 csum_err count", 64'(n_csum), 1);
    chk("R4 no valid", 64'(n_valid + n_code), 0);
    chk("R4 body held", 64'(cmd_body), 64'(prev));
  endtask

  task automatic t_bad_code(logic [7:0] code, string req);
    logic [55:0] prev = cap_body;
    clear_counts();
    send(mk(code, 48'hABCD_EF01_2345, 8'h00), 64, 0);
    chk({req, " code_err count"}, 64'(n_code), 1);
    chk({req, " no valid"}, 64'(n_valid + n_csum), 0);
    chk({req, " body held"}, 64'(cmd_body), 64'(prev));
  endtask

  task automatic t_truncated();
    logic [55:0] prev = cap_body;
    clear_counts();
    send(mk(8'd3, 48'h5555_AAAA_1234, 8'h00), 20, 0);
    chk("R6 frame_err count", 64'(n_frame), 1);
    chk("R6 no valid", 64'(n_valid + n_csum + n_code), 0);
    chk("R6 body held", 64'(cmd_body), 64'(prev));
    t_good(8'd44, 48'h1357_9BDF_0246, "R6 recovery");
  endtask

  task automatic t_overlong();
    logic [63:0] w = mk(8'd21, 48'h0F0F_F0F0_3C3C, 8'h00);
    clear_counts();
    send(w, 64, 9);
    chk("R7 single valid", 64'(n_valid), 1);
    chk("R7 body", 64'(cap_body), 64'(w[63:8]));
    chk("R7 no errors", 64'(n_csum + n_code + n_frame), 0);
  endtask

  task automatic t_gate_low();
    logic [55:0] prev = cap_body;
    clear_counts();
    for (int i = 0; i < 70; i++) begin
      sdata = i[0];
      sclk = 0; wait_clk(HALF_BIT);
      sclk = 1; wait_clk(HALF_BIT);
    end
    sclk = 0; wait_clk(HALF_BIT);
    chk("R2 no pulses", 64'(n_valid + n_csum + n_code + n_frame), 0);
    chk("R2 body held", 64'(cmd_body), 64'(prev));
    t_good(8'd30, 48'hFFFF_0000_FFFF, "R2 after idle clocks");
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1;
    wait_clk(3);
    t_reset();
    t_good(8'd5, 48'h1122_3344_5566, "R1 R3 code5");
    t_good(8'd17, 48'hFEDC_BA98_7654, "R3 code17");
    t_good(8'd0, 48'h0000_0000_0001, "R10 code0");
    t_good(8'd58, 48'hFFFF_FFFF_FFFF, "R10 code58");
    t_bad_code(8'd59, "R10 R5 code59");
    t_bad_code(8'd200, "R5 code200");
    t_bad_sum();
    t_truncated();
    t_overlong();
    t_gate_low();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule